// File: doc/BRIEF.md
# Status Register and Write Guard for a Serial Memory

This block keeps the 8-bit status word of a small serial memory and decides, cycle by cycle, whether a write may start. The command decoder next to it sends strobes: one to arm the write-enable latch, one to disarm it, a status-write strobe with its data byte, and an array-write strobe with the target address. A write timer reports through a busy level how long a self-timed programming cycle lasts. The block returns the status byte for readback and two permission flags, one for status writes and one for array writes.

A write is allowed only when the enable latch is armed, no programming cycle is running and the active-low protect pin is high. An array write must also target an address outside the region that the two block-protect bits select. While a cycle runs, the readback shows the protect bits as they were before the cycle, and the enable and busy bits at their live values. The protect bits stand in for non-volatile cells. They are plain registers that a hard reset clears, and a soft reset of the serial interface leaves them alone.

Top module: `statreg_guard`

## Requirements
- R1: The status byte reads bits 7..4 as 1. Bit 3 is protect bit P1, bit 2 is protect bit P0, bit 1 is the enable latch and bit 0 is the cycle-busy flag. After hard reset the byte reads 8'hF0.
- R2: An accepted status write loads data bits 3 and 2 into P1 and P0. Every other bit of the written byte has no effect on the status byte.
- R3: A set strobe arms the enable latch at the next clock edge if the protect pin is high. The latch clears at the next edge after a clear strobe, after a soft reset, after the end of any programming cycle, and at every edge while the protect pin is low. A clear wins over a set that arrives in the same cycle.
- R4: The busy flag rises at the edge after an accepted status or array write. It stays set while the timer is busy and falls at the first edge after the timer busy level drops.
- R5: While the busy flag is set, status bits 3..2 hold their value from before the cycle. Bits 1..0 stay live. Once the busy flag clears, bits 3..2 show the new protect value.
- R6: The status-write permit is high only when the latch is armed, the busy flag is clear and the protect pin is high. The permit responds combinationally to the pin. A status-write strobe is ignored while the permit is low.
- R7: The array-write permit needs every condition of R6 and also a target address outside the protected region. An array-write strobe is ignored while this permit is low.
- R8: Protect code {P1,P0} selects the region: 00 protects nothing, 01 protects addresses whose two top bits are 11, 10 protects addresses whose top bit is 1, and 11 protects the whole array.
- R9: A soft reset clears only the enable latch and keeps the protect bits. A hard reset clears the protect bits to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| softRst | input | 1 | Soft reset of the serial interface, one-cycle strobe |
| wpN | input | 1 | Protect pin, active low |
| welSet | input | 1 | Arm the enable latch |
| welClr | input | 1 | Disarm the enable latch |
| wrsrCommit | input | 1 | Status-write strobe |
| wrsrData | input | 8 | Status-write data byte |
| arrayCommit | input | 1 | Array-write strobe |
| timerBusy | input | 1 | Busy level from the programming timer |
| tgtAddr | input | ADDR_W | Target address for the protection check |
| statusByte | output | 8 | Status readback |
| wrsrOk | output | 1 | Status write permitted |
| arrayWrOk | output | 1 | Array write permitted |

## Verification
The status byte is checked after each event that can touch the enable latch: set, clear, set and clear together, protect pin low, soft reset and cycle completion. This shows which of the clearing paths wins. One status write uses an all-ones data byte, which shows that only bits 3..2 take the written value. A second status write is sent during the busy window, and the frozen readback shows whether the protect bits change too early. Each protect code is probed with addresses just below and just above its region boundary. Refused status and array writes are issued while the latch is disarmed or the address is locked, and the readback must show that no cycle started.

// File: rtl/statreg_pkg.sv
package statreg_pkg;

  localparam int STATUS_W = 8;
  localparam int P1_POS   = 3;
  localparam int P0_POS   = 2;
  localparam int EN_POS   = 1;
  localparam int BUSY_POS = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic bpLoad;     // accepted status write this cycle
    logic cycleBusy;  // programming cycle in progress
    logic welBit;     // enable latch state
  } sr_strobe_t;

endpackage

// File: rtl/statreg_ctrl.sv
module statreg_ctrl
  import statreg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       wpN,
  input  logic       welSet,
  input  logic       welClr,
  input  logic       wrsrCommit,
  input  logic       arrayCommit,
  input  logic       timerBusy,
  input  logic       inRegion,
  output sr_strobe_t stb,
  output logic       wrsrOk,
  output logic       arrayWrOk
);

  logic wel;
  logic wip;
  logic armed;
  logic gateOk;
  logic wrsrAcc;
  logic arrayAcc;
  logic cycleDone;
  logic welKill;

  // shared write gate: latch armed, idle, pin released
  assign gateOk    = wel & ~wip & wpN;
  assign wrsrOk    = gateOk;
  assign arrayWrOk = gateOk & ~inRegion;

  assign wrsrAcc   = wrsrCommit & wrsrOk;
  assign arrayAcc  = arrayCommit & arrayWrOk;

  // cycle ends once the timer has been seen busy and drops again
  assign cycleDone = wip & armed & ~timerBusy;

  assign welKill   = ~wpN | welClr | softRst | cycleDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel   <= 1'b0;
      wip   <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (welKill)
        wel <= 1'b0;
      else if (welSet)
        wel <= 1'b1;

      if (cycleDone)
        wip <= 1'b0;
      else if (wrsrAcc | arrayAcc)
        wip <= 1'b1;

      if (cycleDone)
        armed <= 1'b0;
      else if (wip & timerBusy)
        armed <= 1'b1;
    end
  end

  always_comb begin
    stb           = '0;
    stb.bpLoad    = wrsrAcc;
    stb.cycleBusy = wip;
    stb.welBit    = wel;
  end

  // R3: a low protect pin leaves the latch disarmed at the next edge
  a_r3_pin_low_disarms: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |=> !wel);

  // R3: clear has priority over a simultaneous set
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (welSet && welClr) |=> !wel);

  // R4: timer drop after a busy stretch ends the cycle and disarms the latch
  a_r4_cycle_ends: assert property (@(posedge clk) disable iff (!rstN)
    (wip && $past(wip) && $past(timerBusy) && !timerBusy) |=> (!wip && !wel));

  // R6: no permit of either kind during a cycle
  a_r6_busy_refuses: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> (!wrsrOk && !arrayWrOk));

  // R7: a locked address never gets the array permit
  a_r7_region_blocks: assert property (@(posedge clk) disable iff (!rstN)
    inRegion |-> !arrayWrOk);

endmodule

// File: rtl/statreg_dp.sv
module statreg_dp
  import statreg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  sr_strobe_t          stb,
  input  logic [STATUS_W-1:0] wrsrData,
  input  logic [ADDR_W-1:0]   tgtAddr,
  output logic [STATUS_W-1:0] statusByte,
  output logic                inRegion
);

  localparam int MSB = ADDR_W - 1;

  logic [1:0] bpReg;   // working protect code
  logic [1:0] bpHeld;  // snapshot shown during a cycle
  logic [1:0] bpView;
  logic       hitHalf;
  logic       hitQuarter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpReg  <= 2'b00;
      bpHeld <= 2'b00;
    end else begin
      if (stb.bpLoad)
        bpReg <= {wrsrData[P1_POS], wrsrData[P0_POS]};
      if (!stb.cycleBusy)
        bpHeld <= bpReg;
    end
  end

  assign bpView = stb.cycleBusy ? bpHeld : bpReg;

  always_comb begin
    statusByte           = '1;
    statusByte[P1_POS]   = bpView[1];
    statusByte[P0_POS]   = bpView[0];
    statusByte[EN_POS]   = stb.welBit;
    statusByte[BUSY_POS] = stb.cycleBusy;
  end

  // region decode from the top address bits
  generate
    if (ADDR_W >= 2) begin : g_wide
      assign hitHalf    = tgtAddr[MSB];
      assign hitQuarter = tgtAddr[MSB] & tgtAddr[MSB-1];
    end else begin : g_narrow
      assign hitHalf    = tgtAddr[MSB];
      assign hitQuarter = tgtAddr[MSB];
    end
  endgenerate

  always_comb begin
    unique case (bpReg)
      2'b00:   inRegion = 1'b0;
      2'b01:   inRegion = hitQuarter;
      2'b10:   inRegion = hitHalf;
      default: inRegion = 1'b1;
    endcase
  end

  // R5: protect readback frozen across a running cycle
  a_r5_frozen_readback: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cycleBusy && $past(stb.cycleBusy)) |->
      (statusByte[P1_POS:P0_POS] == $past(statusByte[P1_POS:P0_POS])));

  // R2: protect code moves only on an accepted status write
  a_r2_load_only: assert property (@(posedge clk) disable iff (!rstN)
    !stb.bpLoad |=> (bpReg == $past(bpReg)));

  // R6: control only loads the code while idle
  a_r6_load_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.bpLoad |-> !stb.cycleBusy);

  // R1: upper nibble of readback is fixed high
  always_comb begin
    if (rstN) a_r1_top_ones: assert (statusByte[7:4] == 4'hF);
  end

endmodule

// File: rtl/statreg_guard.sv
module statreg_guard
  import statreg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              wpN,
  input  logic              welSet,
  input  logic              welClr,
  input  logic              wrsrCommit,
  input  logic [7:0]        wrsrData,
  input  logic              arrayCommit,
  input  logic              timerBusy,
  input  logic [ADDR_W-1:0] tgtAddr,
  output logic [7:0]        statusByte,
  output logic              wrsrOk,
  output logic              arrayWrOk
);

  sr_strobe_t stb;
  logic       inRegion;

  statreg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .softRst     (softRst),
    .wpN         (wpN),
    .welSet      (welSet),
    .welClr      (welClr),
    .wrsrCommit  (wrsrCommit),
    .arrayCommit (arrayCommit),
    .timerBusy   (timerBusy),
    .inRegion    (inRegion),
    .stb         (stb),
    .wrsrOk      (wrsrOk),
    .arrayWrOk   (arrayWrOk)
  );

  statreg_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrsrData   (wrsrData),
    .tgtAddr    (tgtAddr),
    .statusByte (statusByte),
    .inRegion   (inRegion)
  );

endmodule

// File: tb/statreg_guard_tb_top.sv
module statreg_guard_tb_top;

  localparam int ADDR_W = 9;

  logic              clk = 1'b0;
  logic              rstN;
  logic              softRst;
  logic              wpN;
  logic              welSet;
  logic              welClr;
  logic              wrsrCommit;
  logic [7:0]        wrsrData;
  logic              arrayCommit;
  logic              timerBusy;
  logic [ADDR_W-1:0] tgtAddr;
  logic [7:0]        statusByte;
  logic              wrsrOk;
  logic              arrayWrOk;

  int nChecks = 0;
  int nFails  = 0;
  bit doneRun = 0;

  always #2 clk = ~clk;

  statreg_guard #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wpN(wpN),
    .welSet(welSet), .welClr(welClr), .wrsrCommit(wrsrCommit),
    .wrsrData(wrsrData), .arrayCommit(arrayCommit), .timerBusy(timerBusy),
    .tgtAddr(tgtAddr), .statusByte(statusByte), .wrsrOk(wrsrOk),
    .arrayWrOk(arrayWrOk)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // all stimulus tasks start and end on a falling edge
  task automatic pulseWren();
    welSet = 1'b1; @(negedge clk); welSet = 1'b0;
  endtask

  task automatic pulseWrdi();
    welClr = 1'b1; @(negedge clk); welClr = 1'b0;
  endtask

  task automatic doWrsr(input logic [7:0] d);
    wrsrData = d; wrsrCommit = 1'b1; @(negedge clk); wrsrCommit = 1'b0;
  endtask

  task automatic doArray(input logic [ADDR_W-1:0] a);
    tgtAddr = a; arrayCommit = 1'b1; @(negedge clk); arrayCommit = 1'b0;
  endtask

  task automatic runTimer(input int n);
    timerBusy = 1'b1;
    repeat (n) @(negedge clk);
    timerBusy = 1'b0;
    @(negedge clk);
  endtask

  task automatic setBp(input logic [1:0] bp);
    pulseWren();
    doWrsr({4'b0000, bp, 2'b00});
    runTimer(2);
  endtask

  task automatic hardReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 reset status", statusByte, 8'hF0);
    chk("R6 reset wrsr permit", wrsrOk, 1'b0);
    chk("R7 reset array permit", arrayWrOk, 1'b0);
  endtask

  task automatic testLatch();
    pulseWren();
    chk("R3 set arms latch", statusByte, 8'hF2);
    chk("R6 permit when armed", wrsrOk, 1'b1);
    tgtAddr = '1; #1;
    chk("R8 code 00 leaves top address open", arrayWrOk, 1'b1);
    pulseWrdi();
    chk("R3 clear strobe", statusByte, 8'hF0);
    welSet = 1'b1; welClr = 1'b1; @(negedge clk);
    welSet = 1'b0; welClr = 1'b0;
    chk("R3 clear wins over set", statusByte, 8'hF0);
    pulseWren();
    wpN = 1'b0; #1;
    chk("R6 pin low drops permit at once", wrsrOk, 1'b0);
    @(negedge clk);
    chk("R3 pin low disarms", statusByte, 8'hF0);
    pulseWren();
    chk("R3 set ignored with pin low", statusByte, 8'hF0);
    wpN = 1'b1; @(negedge clk);
  endtask

  task automatic testStatusWrite();
    pulseWren();
    doWrsr(8'hFF);
    chk("R4 busy after accepted status write", statusByte, 8'hF3);
    timerBusy = 1'b1;
    @(negedge clk);
    doWrsr(8'h00); // must be ignored while busy
    @(negedge clk);
    chk("R5 frozen protect bits, live enable and busy", statusByte, 8'hF3);
    chk("R6 no status permit while busy", wrsrOk, 1'b0);
    chk("R7 no array permit while busy", arrayWrOk, 1'b0);
    timerBusy = 1'b0;
    @(negedge clk);
    chk("R2 only bits 3..2 taken, R4 busy ends, R3 latch cleared", statusByte, 8'hFC);
  endtask

  task automatic testRefusedStatus();
    doWrsr(8'h00);
    chk("R6 refused status write keeps code", statusByte, 8'hFC);
    @(negedge clk);
    chk("R6 refused status write starts no cycle", statusByte, 8'hFC);
  endtask

  task automatic testRegions();
    pulseWren();
    tgtAddr = 9'h000; #1;
    chk("R8 code 11 locks bottom address", arrayWrOk, 1'b0);
    @(negedge clk);
    doWrsr(8'h08); runTimer(2);
    chk("R2 code 10 loaded", statusByte, 8'hF8);
    pulseWren();
    tgtAddr = 9'h0FF; #1;
    chk("R8 code 10 below half open", arrayWrOk, 1'b1);
    tgtAddr = 9'h100; #1;
    chk("R8 code 10 at half locked", arrayWrOk, 1'b0);
    @(negedge clk);
    doWrsr(8'h04); runTimer(2);
    chk("R2 code 01 loaded", statusByte, 8'hF4);
    pulseWren();
    tgtAddr = 9'h17F; #1;
    chk("R8 code 01 below quarter open", arrayWrOk, 1'b1);
    tgtAddr = 9'h180; #1;
    chk("R8 code 01 at quarter locked", arrayWrOk, 1'b0);
    @(negedge clk);
    doWrsr(8'h00); runTimer(2);
    chk("R2 code 00 loaded", statusByte, 8'hF0);
  endtask

  task automatic testArray();
    pulseWren();
    doArray(9'h1FF);
    chk("R4 busy after accepted array write", statusByte, 8'hF3);
    runTimer(3);
    chk("R3 array completion disarms", statusByte, 8'hF0);
    setBp(2'b11);
    pulseWren();
    doArray(9'h000);
    chk("R7 locked array write starts no cycle", statusByte, 8'hFE);
  endtask

  task automatic testSoftReset();
    softRst = 1'b1; @(negedge clk); softRst = 1'b0;
    chk("R9 soft reset clears latch, keeps code", statusByte, 8'hFC);
    hardReset();
    chk("R9 hard reset clears code", statusByte, 8'hF0);
  endtask

  initial begin
    rstN = 1'b0; softRst = 1'b0; wpN = 1'b1; welSet = 1'b0; welClr = 1'b0;
    wrsrCommit = 1'b0; wrsrData = '0; arrayCommit = 1'b0; timerBusy = 1'b0;
    tgtAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLatch();
    testStatusWrite();
    testRefusedStatus();
    testRegions();
    testArray();
    testSoftReset();
    doneRun = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneRun) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual hung expected finished");
      summary();
    end
  end

endmodule